// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing half of a small byte-wide nonvolatile store of 128 locations, held here in a register array. It watches a clock line and a data line from a two-wire bus, removes short glitches from both, detects start and stop conditions, and shifts bytes in and out. The first byte after a start carries a 7-bit word address and a direction bit. Each byte the block accepts is acknowledged by pulling the data line low on the ninth clock.

Write data is not placed in the array byte by byte. It is collected in a four-entry page buffer, and the buffer is copied into the array in one step, only when a stop condition ends a write that delivered at least one whole data byte. A self-timed program interval then starts. For its whole length the block does not drive the bus and does not react to it, so a master polls for completion by watching for an acknowledge. Reads return bytes MSB first from a pointer that steps through the entire address space. After reset, a power-up interval has to expire before the block answers at all.

Top module: `eep_slave`

## Requirements
- R1: From reset `sda_oe` is low, and no byte is acknowledged until `PWR_CYCLES` clocks have passed since reset was released.
- R2: A pulse on either bus line that lasts fewer than `FILT_LEN` clocks is ignored. It causes no clock edge, start or stop, and data written across such pulses is stored unchanged.
- R3: The first byte after a start carries the word address in bits 7..1 and the direction in bit 0 (1 = read, 0 = write). It is sent MSB first.
- R4: While the block is responsive, every complete address byte and every complete write data byte is acknowledged by driving the data line low throughout the ninth clock's high phase.
- R5: Each write data byte goes into page slot `addr[1:0]`. After each byte only the low two address bits advance, wrapping inside the 4-byte page, so a fifth byte and later bytes overwrite earlier slots and the array outside the page is never touched.
- R6: The array changes only at a stop condition that follows at least one complete data byte. A stop after only the address byte, a stop in the middle of a data byte, or a repeated start discards the staged bytes and starts no program interval.
- R7: For `WR_CYCLES` clocks after a commit the block ignores the bus entirely, including start conditions. It acknowledges nothing and changes nothing. Afterwards it responds normally.
- R8: A read returns the byte at the current address and then increments the full 7-bit address, wrapping from 127 to 0. A master acknowledge continues the read, and a master no-acknowledge ends it, with the data line released.
- R9: After reset every array location reads 0xFF.
- R10: `sda_oe` changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired-AND level) |
| sda_oe | output | 1 | When high, the pad pulls the data line low |

## Verification
The main function is exercised with page writes of exactly four bytes from an aligned address and of six bytes from a mid-page address. The six-byte case separates a correct in-page wrap from spilling into the next page or into the byte before the page. Reads run across the 127-to-0 boundary, which shows whether the pointer is seven bits wide or is wrapped inside the page. Several aborted writes (address only, half a byte, a repeated start) are each followed at once by a transaction that must be acknowledged, so that a spurious program interval shows up as a missing acknowledge. A write sent with short glitches on both lines must store the intended byte. If the filter let a glitch through, the byte would come out shifted or the transfer would be aborted.

// File: rtl/eep_pkg.sv
package eep_pkg;

  parameter int unsigned ADDR_W = 7;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned PAGE_W = 2;

  typedef logic [ADDR_W-1:0] waddr_t;
  typedef logic [DATA_W-1:0] wbyte_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } eng_state_t;

  // Next write slot: only the in-page bits advance.
  function automatic waddr_t page_next(input waddr_t a);
    waddr_t r;
    r = a;
    r[PAGE_W-1:0] = a[PAGE_W-1:0] + 1'b1;
    return r;
  endfunction

  // Next read location: the full address advances and wraps.
  function automatic waddr_t lin_next(input waddr_t a);
    return a + 1'b1;
  endfunction

endpackage

// File: rtl/eep_glitch_filter.sv
module eep_glitch_filter #(
  parameter int unsigned FILT_LEN = 25,
  parameter logic        IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] run_q;

  // Output follows the synchronised input only after FILT_LEN
  // consecutive samples disagree with it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {2{IDLE_LVL}};
      run_q  <= '0;
      dout   <= IDLE_LVL;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout) begin
        run_q <= '0;
      end else if (run_q == CW'(FILT_LEN - 1)) begin
        dout  <= sync_q[1];
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/eep_countdown.sv
module eep_countdown #(
  parameter int unsigned CYCLES     = 1,
  parameter bit          START_FULL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= START_FULL ? CW'(CYCLES) : '0;
    else if (load)         cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/eep_bus_engine.sv
module eep_bus_engine
  import eep_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   enable,
  input  logic   scl_f,
  input  logic   sda_f,
  input  wbyte_t rd_data,
  output logic   sda_oe,
  output waddr_t addr,
  output logic   stage_we,
  output wbyte_t stage_data,
  output logic   stage_clr,
  output logic   commit,
  output logic   ev_start,
  output logic   ev_stop
);
  localparam int unsigned BCW = $clog2(DATA_W + 1);

  eng_state_t    state_q;
  logic          scl_q, sda_q;
  logic [BCW-1:0] bit_q;
  wbyte_t        shift_q, out_q;
  logic          rw_q, staged_q, mack_q;
  logic          scl_rise, scl_fall, byte_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign ev_start  = enable & scl_f & scl_q & sda_q & ~sda_f;
  assign ev_stop   = enable & scl_f & scl_q & ~sda_q & sda_f;
  assign byte_full = (bit_q == BCW'(DATA_W));

  assign stage_we   = enable & scl_fall & byte_full & (state_q == ST_WDATA);
  assign stage_data = shift_q;
  assign stage_clr  = ev_start;
  assign commit     = ev_stop & staged_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      shift_q  <= '0;
      out_q    <= '0;
      addr     <= '0;
      rw_q     <= 1'b0;
      staged_q <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (!enable) begin
      state_q  <= ST_IDLE;
      sda_oe   <= 1'b0;
      staged_q <= 1'b0;
    end else if (ev_start) begin
      state_q  <= ST_ADDR;
      bit_q    <= '0;
      sda_oe   <= 1'b0;
      staged_q <= 1'b0;
    end else if (ev_stop) begin
      state_q  <= ST_IDLE;
      sda_oe   <= 1'b0;
      staged_q <= 1'b0;
    end else begin
      if (scl_rise) begin
        unique case (state_q)
          ST_ADDR, ST_WDATA: begin
            shift_q <= {shift_q[DATA_W-2:0], sda_f};
            bit_q   <= bit_q + 1'b1;
          end
          ST_RDATA: bit_q  <= bit_q + 1'b1;
          ST_RACK:  mack_q <= ~sda_f;
          default: ;
        endcase
      end
      if (scl_fall) begin
        unique case (state_q)
          ST_ADDR: if (byte_full) begin
            addr    <= shift_q[DATA_W-1:1];
            rw_q    <= shift_q[0];
            state_q <= ST_AACK;
            sda_oe  <= 1'b1;
          end
          ST_WDATA: if (byte_full) begin
            addr     <= page_next(addr);
            staged_q <= 1'b1;
            state_q  <= ST_WACK;
            sda_oe   <= 1'b1;
          end
          ST_AACK, ST_RACK: begin
            if ((state_q == ST_AACK && rw_q) || (state_q == ST_RACK && mack_q)) begin
              out_q   <= rd_data;
              sda_oe  <= ~rd_data[DATA_W-1];
              addr    <= lin_next(addr);
              bit_q   <= '0;
              state_q <= ST_RDATA;
            end else if (state_q == ST_AACK) begin
              sda_oe  <= 1'b0;
              bit_q   <= '0;
              state_q <= ST_WDATA;
            end else begin
              sda_oe  <= 1'b0;
              state_q <= ST_IDLE;
            end
          end
          ST_WACK: begin
            sda_oe  <= 1'b0;
            bit_q   <= '0;
            state_q <= ST_WDATA;
          end
          ST_RDATA: begin
            if (byte_full) begin
              sda_oe  <= 1'b0;
              state_q <= ST_RACK;
            end else begin
              sda_oe <= ~out_q[DATA_W-2];
              out_q  <= {out_q[DATA_W-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eep_store.sv
module eep_store
  import eep_pkg::*;
#(
  parameter wbyte_t ERASED = 8'hFF
) (
  input  logic   clk,
  input  logic   rst_n,
  input  waddr_t rd_addr,
  output wbyte_t rd_data,
  input  logic   stage_we,
  input  waddr_t stage_addr,
  input  wbyte_t stage_data,
  input  logic   stage_clr,
  input  logic   commit
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned PAGE  = 1 << PAGE_W;

  wbyte_t                   mem_q     [DEPTH];
  wbyte_t                   pg_data_q [PAGE];
  logic                     vld_q     [PAGE];
  logic [ADDR_W-PAGE_W-1:0] base_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        base_q <= '0;
    else if (stage_we) base_q <= stage_addr[ADDR_W-1:PAGE_W];
  end

  for (genvar s = 0; s < PAGE; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pg_data_q[s] <= '0;
        vld_q[s]     <= 1'b0;
      end else if (stage_clr || commit) begin
        vld_q[s] <= 1'b0;
      end else if (stage_we && stage_addr[PAGE_W-1:0] == PAGE_W'(s)) begin
        pg_data_q[s] <= stage_data;
        vld_q[s]     <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED;
    end else if (commit) begin
      for (int s = 0; s < PAGE; s++) begin
        if (vld_q[s]) mem_q[{base_q, PAGE_W'(s)}] <= pg_data_q[s];
      end
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/eep_slave.sv
module eep_slave
  import eep_pkg::*;
#(
  parameter int unsigned FILT_LEN   = 25,
  parameter int unsigned WR_CYCLES  = 2500000,
  parameter int unsigned PWR_CYCLES = 250000,
  parameter wbyte_t      ERASED     = 8'hFF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic [1:0] raw_w, flt_w;
  logic       scl_flt, sda_flt;
  logic       wr_busy, pwr_wait, pwr_ready, enable;
  logic       stage_we, stage_clr, commit_w, ev_start_w, ev_stop_w;
  waddr_t     addr_w;
  wbyte_t     rd_data_w, stage_data_w;

  assign raw_w = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_flt
    eep_glitch_filter #(.FILT_LEN(FILT_LEN), .IDLE_LVL(1'b1)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_w[g]),
      .dout (flt_w[g])
    );
  end

  assign scl_flt = flt_w[0];
  assign sda_flt = flt_w[1];

  eep_countdown #(.CYCLES(PWR_CYCLES), .START_FULL(1'b1)) u_pwr (
    .clk(clk), .rst_n(rst_n), .load(1'b0), .active(pwr_wait)
  );

  eep_countdown #(.CYCLES(WR_CYCLES), .START_FULL(1'b0)) u_prog (
    .clk(clk), .rst_n(rst_n), .load(commit_w), .active(wr_busy)
  );

  assign pwr_ready = ~pwr_wait;
  assign enable    = pwr_ready & ~wr_busy;

  eep_bus_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .scl_f     (scl_flt),
    .sda_f     (sda_flt),
    .rd_data   (rd_data_w),
    .sda_oe    (sda_oe),
    .addr      (addr_w),
    .stage_we  (stage_we),
    .stage_data(stage_data_w),
    .stage_clr (stage_clr),
    .commit    (commit_w),
    .ev_start  (ev_start_w),
    .ev_stop   (ev_stop_w)
  );

  eep_store #(.ERASED(ERASED)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr   (addr_w),
    .rd_data   (rd_data_w),
    .stage_we  (stage_we),
    .stage_addr(addr_w),
    .stage_data(stage_data_w),
    .stage_clr (stage_clr),
    .commit    (commit_w)
  );
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic sda_oe,
  input logic busy,
  input logic ready,
  input logic commit,
  input logic ev_start,
  input logic ev_stop
);
  AST_QUIET_PWRUP: assert property (@(posedge clk) disable iff (!rst_n) !ready |-> !sda_oe); // R1
  AST_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !sda_oe); // R7
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !ev_start); // R7
  AST_COMMIT_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) commit |=> busy); // R6
  AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n) commit |-> ev_stop); // R6
  AST_OE_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (scl_f && $past(scl_f)) |-> $stable(sda_oe)); // R10
endmodule

bind eep_slave eep_slave_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_f   (scl_flt),
  .sda_oe  (sda_oe),
  .busy    (wr_busy),
  .ready   (pwr_ready),
  .commit  (commit_w),
  .ev_start(ev_start_w),
  .ev_stop (ev_stop_w)
);

// File: tb/tb_eep_slave.sv
module tb_eep_slave;
  localparam int FILT = 8;
  localparam int WR   = 3000;
  localparam int PWR  = 3000;
  localparam int Q    = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int busy_end = 0;
  bit done = 0;
  logic [7:0] ref_mem [128];
  logic [7:0] wq [$];

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  eep_slave #(.FILT_LEN(FILT), .WR_CYCLES(WR), .PWR_CYCLES(PWR)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  always @(posedge clk) if (rst_n) cyc++;

  // Every clock: the data driver must hold while the clock line is high (R10).
  logic scl_prev = 1'b1;
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_m && scl_prev) begin
        n_cmp++;
        if (sda_oe !== oe_prev) begin
          n_bad++;
          $display("FAIL R10 sda_oe moved with SCL high: actual %b expected %b", sda_oe, oe_prev);
        end
      end
      scl_prev = scl_m;
      oe_prev  = sda_oe;
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit live();
    return (cyc >= PWR + 64) && (cyc >= busy_end);
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_live();
    while (!live()) hold(1);
  endtask

  task automatic m_start();
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(2*Q);
    sda_m = 1'b0; hold(2*Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic m_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(2*Q);
    sda_m = 1'b1; hold(2*Q);
  endtask

  task automatic m_bit_out(input logic b, input bit gl);
    sda_m = b;
    if (gl) begin
      hold(Q/2); scl_m = 1'b1; hold(4); scl_m = 1'b0; hold(Q - Q/2 - 4);
    end else hold(Q);
    scl_m = 1'b1;
    if (gl) begin
      hold(Q/2); sda_m = ~b; hold(4); sda_m = b; hold(2*Q - Q/2 - 4);
    end else hold(2*Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic m_bit_in(output logic b);
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    b = sda_line; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] d, input bit gl, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) m_bit_out(d[i], gl);
    m_bit_in(b);
    ack = ~b;
  endtask

  task automatic m_rbyte(input bit mack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_bit_in(b);
      d[i] = b;
    end
    m_bit_out(~mack, 1'b0);
  endtask

  // Page write with reference model of staging and commit.
  task automatic do_write(input int a, input int n, input bit gl, input string req);
    bit lv, any;
    logic ack;
    logic [7:0] pb [4];
    bit v [4];
    int p;
    lv = live();
    any = 0;
    p = a;
    for (int i = 0; i < 4; i++) v[i] = 0;
    m_start();
    m_wbyte({a[6:0], 1'b0}, 1'b0, ack);
    chk(req, "address ack", {7'd0, ack}, {7'd0, lv});
    for (int k = 0; k < n; k++) begin
      m_wbyte(wq[k], gl && (k == 0), ack);
      chk(req, "data ack", {7'd0, ack}, {7'd0, lv});
      if (lv) begin
        pb[p % 4] = wq[k];
        v[p % 4] = 1;
        any = 1;
        p = (p & ~3) | ((p + 1) & 3);
      end
    end
    m_stop();
    if (lv && any) begin
      for (int i = 0; i < 4; i++) if (v[i]) ref_mem[(a & ~3) + i] = pb[i];
      busy_end = cyc + WR + 64;
    end
  endtask

  task automatic do_read(input int a, input int n, input string req);
    bit lv;
    logic ack;
    logic [7:0] d;
    lv = live();
    m_start();
    m_wbyte({a[6:0], 1'b1}, 1'b0, ack);
    chk(req, "read address ack", {7'd0, ack}, {7'd0, lv});
    for (int k = 0; k < n; k++) begin
      m_rbyte(k < n - 1, d);
      chk(req, $sformatf("read byte at %0d", (a + k) % 128), d, lv ? ref_mem[(a + k) % 128] : 8'hFF);
    end
    chk("R8", "line released after master nack", {7'd0, sda_oe}, 8'h00);
    m_stop();
  endtask

  task automatic do_partial(input int a);
    logic ack;
    m_start();
    m_wbyte({a[6:0], 1'b0}, 1'b0, ack);
    chk("R6", "partial write address ack", {7'd0, ack}, 8'h01);
    for (int i = 0; i < 4; i++) m_bit_out(i[0], 1'b0);
    m_stop();
  endtask

  task automatic do_restart(input int a);
    logic ack;
    logic [7:0] d;
    m_start();
    m_wbyte({a[6:0], 1'b0}, 1'b0, ack);
    chk("R6", "restart write address ack", {7'd0, ack}, 8'h01);
    m_wbyte(8'h11, 1'b0, ack);
    chk("R6", "restart staged byte ack", {7'd0, ack}, 8'h01);
    m_start();
    m_wbyte({a[6:0], 1'b1}, 1'b0, ack);
    chk("R3", "restart read address ack", {7'd0, ack}, 8'h01);
    m_rbyte(1'b0, d);
    chk("R6", "staged byte not committed", d, ref_mem[a]);
    m_stop();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) ref_mem[i] = 8'hFF;
    hold(10);
    rst_n = 1'b1;
    hold(2);
    chk("R1", "sda_oe after reset", {7'd0, sda_oe}, 8'h00);

    // Attempt before the power-up interval: all bytes unanswered.
    wq = '{8'h99};
    do_write(8, 1, 1'b0, "R1");
    wait_live();

    do_read(5, 2, "R9");

    // Aligned four-byte page, then an attempt inside the busy window.
    wq = '{8'h11, 8'h22, 8'h33, 8'h44};
    do_write(16, 4, 1'b0, "R4");
    wq = '{8'h77};
    do_write(64, 1, 1'b0, "R7");
    wait_live();
    do_read(16, 4, "R5");
    do_read(64, 1, "R7");

    // Six bytes from mid-page: in-page wrap and overwrite.
    wq = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5};
    do_write(34, 6, 1'b0, "R5");
    wait_live();
    do_read(31, 6, "R5");

    // Aborted writes start no program interval.
    do_write(96, 0, 1'b0, "R6");
    do_partial(96);
    do_read(96, 1, "R6");
    do_restart(48);
    do_read(48, 1, "R6");

    // Sequential read across the top of the array.
    wq = '{8'h5E, 8'h5F};
    do_write(126, 2, 1'b0, "R3");
    wait_live();
    wq = '{8'h60, 8'h61};
    do_write(0, 2, 1'b0, "R3");
    wait_live();
    do_read(126, 4, "R8");

    // Glitches on both lines during a data byte.
    wq = '{8'h5A};
    do_write(80, 1, 1'b1, "R2");
    wait_live();
    do_read(80, 1, "R2");

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule